// File: doc/BRIEF.md
# Duty-Limited Pulsed Load Generator

This block produces the gate signal for an electronic load switch that pulls pulses of current from a high-current supply rail under test. Software, or a test sequencer, writes a period and an on-time, both counted in clock cycles, through a small write port. The block repeats a pulse at that rate. Each period starts with the gate high and ends with it low.

Whatever is programmed, the waveform stays inside fixed safety limits. The period is held between a shortest and a longest allowed value, which by default correspond to 100 kHz and 1 kHz at a 50 MHz clock. The on-time never exceeds half the period, and it never exceeds an absolute ceiling, 100 µs by default. Writes land in staging registers. A new setting is taken up only when a period starts, so a pulse that is already under way is never cut short or lengthened.

An enable input starts and stops the waveform. Dropping it pulls the gate low in the same cycle. Raising it again begins a new period.

Top module: `dpl_pulse_gen`

## Requirements
- R1: While reset is high, and after it is released until enable is first raised, `gate` is 0 and `period_clamped` is 0.
- R2: With enable held high, `gate` rises once every P cycles, where P is the programmed period clamped to the range [MIN_PERIOD_CYC, MAX_PERIOD_CYC].
- R3: Each pulse stays high for T consecutive cycles at the start of the period, where T = min(programmed on-time, floor(P/2), MAX_ON_CYC).
- R4: An on-time setting of 0 keeps `gate` low for every cycle.
- R5: The high time never exceeds floor(P/2) cycles, which caps the duty cycle at 50 %.
- R6: The high time never exceeds MAX_ON_CYC cycles, whatever period is programmed.
- R7: A period below MIN_PERIOD_CYC is raised to MIN_PERIOD_CYC, and a period above MAX_PERIOD_CYC is lowered to MAX_PERIOD_CYC. `period_clamped` becomes 1 when a clamped period is taken into use and returns to 0 when an in-range period is taken into use.
- R8: A write does not change the period that is under way. New settings apply from the next period start.
- R9: When `en` is 0, `gate` is 0 in that same cycle and the period count is reset. After `en` is raised and sampled at a clock edge, `gate` is high in the following cycle (for T > 0), and a complete fresh pulse of T cycles follows.
- R10: A write with `wr_sel` = 0 sets the period and a write with `wr_sel` = 1 sets the on-time. After reset the staged period is MAX_PERIOD_CYC and the staged on-time is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Runs the waveform when high; forces the gate low when low |
| wr_en | input | 1 | Write strobe for the staging registers |
| wr_sel | input | 1 | Register select: 0 = period, 1 = on-time |
| wr_data | input | 32 | Value to write, in clock cycles |
| gate | output | 1 | Drive to the load switch |
| period_clamped | output | 1 | High while the period in use was clamped into range |

## Verification
The case that is hardest to reach from the ports is a write that arrives while a pulse is high. The write must leave that pulse at its full old width and change only the next one. To reach it, the bench first locks onto a rising edge of the gate. It then issues the on-time write on the second high cycle and counts the remaining high cycles of the same pulse. Dropping enable in the middle of a pulse is reached in the same way, and a behavioural model that runs every clock covers the cycles in between.

// File: rtl/dpl_pkg.sv
package dpl_pkg;

    localparam int CFG_W = 32;

    typedef logic [CFG_W-1:0] cyc_t;

    typedef enum logic {
        SEL_PERIOD = 1'b0,
        SEL_ONTIME = 1'b1
    } reg_sel_e;

    typedef struct packed {
        cyc_t period;
        cyc_t on_cyc;
    } wave_cfg_t;

    function automatic cyc_t clamp_range(input cyc_t v, input cyc_t lo, input cyc_t hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

    function automatic cyc_t min3(input cyc_t a, input cyc_t b, input cyc_t c);
        cyc_t m;
        m = (a < b) ? a : b;
        return (m < c) ? m : c;
    endfunction

endpackage

// File: rtl/dpl_shadow.sv
module dpl_shadow
    import dpl_pkg::*;
#(
    parameter cyc_t RST_PERIOD = 32'd50000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      wr_sel,
    input  cyc_t      wr_data,
    output wave_cfg_t staged
);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged.period <= RST_PERIOD;
            staged.on_cyc <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_PERIOD: staged.period <= wr_data;
                SEL_ONTIME: staged.on_cyc <= wr_data;
                default:    staged.period <= staged.period;
            endcase
        end
    end

endmodule

// File: rtl/dpl_limiter.sv
module dpl_limiter
    import dpl_pkg::*;
#(
    parameter cyc_t MIN_PERIOD_CYC = 32'd500,
    parameter cyc_t MAX_PERIOD_CYC = 32'd50000,
    parameter cyc_t MAX_ON_CYC     = 32'd5000
) (
    input  wave_cfg_t staged,
    output wave_cfg_t safe,
    output logic      clipped
);

    cyc_t per_c;

    always_comb begin
        per_c       = clamp_range(staged.period, MIN_PERIOD_CYC, MAX_PERIOD_CYC);
        clipped     = (per_c != staged.period);
        safe.period = per_c;
        safe.on_cyc = min3(staged.on_cyc, per_c >> 1, MAX_ON_CYC);
    end

endmodule

// File: rtl/dpl_sequencer.sv
module dpl_sequencer
    import dpl_pkg::*;
#(
    parameter cyc_t MIN_PERIOD_CYC = 32'd500,
    parameter cyc_t MAX_PERIOD_CYC = 32'd50000,
    parameter cyc_t MAX_ON_CYC     = 32'd5000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  wave_cfg_t safe,
    input  logic      clipped,
    output logic      gate,
    output logic      period_clamped
);

    wave_cfg_t act;
    cyc_t      cnt;
    logic      running;
    logic      boundary;

    assign boundary = !running || (cnt == act.period - cyc_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            act.period     <= MAX_PERIOD_CYC;
            act.on_cyc     <= '0;
            cnt            <= '0;
            running        <= 1'b0;
            period_clamped <= 1'b0;
        end else if (!en) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (boundary) begin
            act            <= safe;
            period_clamped <= clipped;
            cnt            <= '0;
            running        <= 1'b1;
        end else begin
            cnt <= cnt + cyc_t'(1);
        end
    end

    assign gate = en && running && (cnt < act.on_cyc);

    AST_DUTY_CAP: assert property (@(posedge clk) disable iff (rst)
        act.on_cyc <= (act.period >> 1)); // R5

    AST_ON_CEILING: assert property (@(posedge clk) disable iff (rst)
        act.on_cyc <= MAX_ON_CYC); // R6

    AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (act.period >= MIN_PERIOD_CYC) && (act.period <= MAX_PERIOD_CYC)); // R7

    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
        (en && running && !boundary) |=> $stable(act)); // R8

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && running && !boundary) |=> (cnt == $past(cnt) + cyc_t'(1))); // R2

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0) && !running); // R9

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        cnt < act.period); // R2

endmodule

// File: rtl/dpl_pulse_gen.sv
module dpl_pulse_gen
    import dpl_pkg::*;
#(
    parameter int unsigned CLK_HZ         = 50_000_000,
    parameter cyc_t        MIN_PERIOD_CYC = cyc_t'(CLK_HZ / 100_000),
    parameter cyc_t        MAX_PERIOD_CYC = cyc_t'(CLK_HZ / 1_000),
    parameter cyc_t        MAX_ON_CYC     = cyc_t'(CLK_HZ / 10_000)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    output logic             gate,
    output logic             period_clamped
);

    wave_cfg_t staged;
    wave_cfg_t safe;
    logic      clipped;

    dpl_shadow #(
        .RST_PERIOD (MAX_PERIOD_CYC)
    ) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .staged  (staged)
    );

    dpl_limiter #(
        .MIN_PERIOD_CYC (MIN_PERIOD_CYC),
        .MAX_PERIOD_CYC (MAX_PERIOD_CYC),
        .MAX_ON_CYC     (MAX_ON_CYC)
    ) u_limiter (
        .staged  (staged),
        .safe    (safe),
        .clipped (clipped)
    );

    dpl_sequencer #(
        .MIN_PERIOD_CYC (MIN_PERIOD_CYC),
        .MAX_PERIOD_CYC (MAX_PERIOD_CYC),
        .MAX_ON_CYC     (MAX_ON_CYC)
    ) u_sequencer (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .safe           (safe),
        .clipped        (clipped),
        .gate           (gate),
        .period_clamped (period_clamped)
    );

    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (rst)
        (!en && !$past(en)) |-> !gate); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !period_clamped); // R1

endmodule

// File: tb/test_dpl_pulse_gen.sv
module test_dpl_pulse_gen;

    localparam int MINP  = 8;
    localparam int MAXP  = 40;
    localparam int MAXON = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        gate;
    logic        period_clamped;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    dpl_pulse_gen #(
        .CLK_HZ         (50_000_000),
        .MIN_PERIOD_CYC (32'(MINP)),
        .MAX_PERIOD_CYC (32'(MAXP)),
        .MAX_ON_CYC     (32'(MAXON))
    ) i_dpl_pulse_gen (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .wr_en          (wr_en),
        .wr_sel         (wr_sel),
        .wr_data        (wr_data),
        .gate           (gate),
        .period_clamped (period_clamped)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model: staged values, current period length,
    // allowed high time and position inside the period.
    int  s_per = MAXP, s_on = 0;
    int  m_per = MAXP, m_on = 0, m_pos = 0, m_flag = 0;
    bit  m_live = 0;

    function automatic int lim_per(input int p);
        if (p < MINP) return MINP;
        if (p > MAXP) return MAXP;
        return p;
    endfunction

    function automatic int lim_on(input int t, input int p);
        int r;
        r = t;
        if (r > p / 2) r = p / 2;
        if (r > MAXON) r = MAXON;
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            s_per = MAXP; s_on = 0; m_per = MAXP; m_on = 0;
            m_pos = 0; m_flag = 0; m_live = 0;
        end else begin
            if (!en) begin
                m_live = 0; m_pos = 0;
            end else if (!m_live || m_pos == m_per - 1) begin
                m_per  = lim_per(s_per);
                m_on   = lim_on(s_on, m_per);
                m_flag = (m_per != s_per) ? 1 : 0;
                m_pos  = 0;
                m_live = 1;
            end else begin
                m_pos++;
            end
            if (wr_en) begin
                if (wr_sel) s_on = int'(wr_data);
                else        s_per = int'(wr_data);
            end
        end
    end

    // Compare against the model on every clock, away from the edge.
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            chk("R3 gate vs model", int'(gate), (en && m_live && m_pos < m_on) ? 1 : 0);
            chk("R7 clamp flag vs model", int'(period_clamped), m_flag);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic wr(input bit sel, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = 32'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Locks onto a rising gate edge, then returns the high time and the
    // rise-to-rise period; returns at the sample of the next rise.
    task automatic measure(output int hi, output int per);
        bit prev;
        int t;
        hi = -1; per = -1; t = 0;
        @(negedge clk); #2;
        prev = gate;
        forever begin
            @(negedge clk); #2;
            if (gate && !prev) break;
            prev = gate;
            t++;
            if (t > 3000) return;
        end
        hi = 0;
        do begin
            hi++;
            @(negedge clk); #2;
        end while (gate && hi < 3000);
        per = hi;
        while (!gate && per < 3000) begin
            per++;
            @(negedge clk); #2;
        end
    endtask

    task automatic settle_and_measure(input string tag, input int exp_hi, input int exp_per);
        int h, p;
        measure(h, p);
        measure(h, p);
        chk({tag, " high time"}, h, exp_hi);
        chk({tag, " period"}, p, exp_per);
    endtask

    initial begin
        int h, p, highs;
        repeat (4) @(negedge clk);
        #2;
        chk("R1 gate in reset", int'(gate), 0);
        chk("R1 flag in reset", int'(period_clamped), 0);
        @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        chk("R1 gate idle after reset", int'(gate), 0);

        // R10: select 0 = period, select 1 = on-time
        wr(1'b0, 20); wr(1'b1, 6);
        @(negedge clk); en = 1'b1;
        settle_and_measure("R2 R3 R10 P20 T6", 6, 20);

        wr(1'b1, 15);
        settle_and_measure("R5 half-period cap", 10, 20);

        wr(1'b0, 40); wr(1'b1, 30);
        settle_and_measure("R6 absolute cap", 12, 40);
        chk("R7 in-range flag", int'(period_clamped), 0);

        wr(1'b0, 100);
        settle_and_measure("R7 clamp high", 12, 40);
        chk("R7 flag after high clamp", int'(period_clamped), 1);

        wr(1'b0, 3);
        settle_and_measure("R7 clamp low", 4, 8);
        chk("R7 flag after low clamp", int'(period_clamped), 1);

        wr(1'b0, 20); wr(1'b1, 6);
        settle_and_measure("R7 back in range", 6, 20);
        chk("R7 flag cleared", int'(period_clamped), 0);

        // R4: zero on-time
        wr(1'b1, 0);
        repeat (45) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); #2;
            if (gate) highs++;
        end
        chk("R4 zero on-time high cycles", highs, 0);

        // R8: write during a pulse keeps that pulse intact
        wr(1'b1, 6);
        measure(h, p);
        measure(h, p);
        h = 1;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'd2;
        #2;
        while (gate && h < 100) begin
            h++;
            @(negedge clk);
            wr_en = 1'b0;
            #2;
        end
        wr_en = 1'b0;
        chk("R8 pulse in flight unchanged", h, 6);
        measure(h, p);
        chk("R8 next pulse uses new value", h, 2);

        // R9: enable drop mid-pulse, then restart
        wr(1'b1, 6);
        measure(h, p);
        measure(h, p);
        @(negedge clk); en = 1'b0;
        #2;
        chk("R9 gate low same cycle", int'(gate), 0);
        highs = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #2;
            if (gate) highs++;
        end
        chk("R9 gate held low", highs, 0);
        @(negedge clk); en = 1'b1;
        #2;
        chk("R9 not yet started", int'(gate), 0);
        @(negedge clk); #2;
        chk("R9 fresh period starts high", int'(gate), 1);
        h = 0;
        while (gate && h < 100) begin
            h++;
            @(negedge clk); #2;
        end
        chk("R9 fresh pulse width", h, 6);

        repeat (5) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule